// File: doc/BRIEF.md
# Back-Porch Offset Trim Loop

This block closes a slow digital loop around one ADC channel so that the channel settles on a programmed black-level code. Each time the clamp strobe drops, it averages the next sixteen conversion results. It compares that average with a signed target code and nudges a signed offset correction word by one LSB in the direction that moves the average toward the target. An external offset DAC applies the correction word to the analog path.

The loop can act on every measurement or only on one in 16, 64 or 192 clamp events. It can also stop itself after a single update, so that it calibrates once and then stays frozen. When automatic trimming is turned off, a manual signed offset passes straight to the output, and the learned correction is kept for later use.

Top module: `backporch_offset_trim`

## Requirements
- R1: After reset the learned correction is 0. With auto mode on, `offset_o` reads 0 until the first applied update.
- R2: A measurement covers exactly the 16 samples on the 16 rising edges that start with the first edge at which `clamp_i` is seen low after being high. The average is the 14-bit sum shifted right by 4, and samples outside the window do not contribute. The updated correction appears after the rising edge that follows the 16th sample.
- R3: `target_i` is 11-bit two's complement (-1024..+1023). The error is target minus average, taken in 12-bit signed arithmetic. An error above +1 raises the correction by 1, an error below -1 lowers it by 1, and an error of -1, 0 or +1 leaves it unchanged.
- R4: The correction saturates at +255 and -255 and never leaves that range.
- R5: A measurement that completes while `target_i` is 0 changes nothing. It also does not count as the single update in hold mode.
- R6: If `clamp_i` goes high again before the 16th sample, that measurement is dropped and no update follows from it.
- R7: `rate_i` selects how often an update is applied: 2'b00 every clamp end, 2'b01 every 16th, 2'b10 every 64th, 2'b11 every 192nd. Clamp ends are counted from reset, so with 2'b01 the 16th clamp end after reset is the first one applied.
- R8: While `hold_i` is high, only one update is applied. After that the correction stays frozen until `hold_i` falls or auto mode is turned off.
- R9: With `auto_en_i` low, `offset_o` equals `manual_i` (9-bit signed, ±255). No update is applied, and the learned correction returns unchanged on `offset_o` when auto mode is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en_i | input | 1 | 1 selects the automatic loop, 0 selects the manual offset |
| hold_i | input | 1 | One-shot mode: freeze after a single update |
| rate_i | input | 2 | Update-rate select (1, 16, 64 or 192 clamp ends) |
| target_i | input | 11 | Signed black-level target code; 0 is ignored |
| manual_i | input | 9 | Signed manual offset used when auto mode is off |
| sample_i | input | 10 | Unsigned conversion result, one per clock |
| clamp_i | input | 1 | Clamp-active strobe, high during the clamp pulse |
| offset_o | output | 9 | Signed offset correction word |

## Verification
The correction is due on the 17th rising edge counted from the first edge that sees the clamp low, and no earlier. The bench drives inputs on falling edges. It holds the window data for exactly sixteen falling-edge steps, changes the data to an out-of-range value, waits one more falling edge and then samples `offset_o`. In this way an off-by-one window or a late update shows as a wrong value. The manual bypass is combinational and is checked on the falling edge right after the change. Rate and hold checks read `offset_o` after each complete pulse, so an update applied one event early or late is seen.

// File: rtl/bpo_pkg.sv
package bpo_pkg;

  typedef enum logic [1:0] {
    RATE_EVERY_1   = 2'b00,
    RATE_EVERY_16  = 2'b01,
    RATE_EVERY_64  = 2'b10,
    RATE_EVERY_192 = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

  localparam int unsigned EVT_W = 8;

  // last event index of a rate period (period minus one)
  function automatic logic [EVT_W-1:0] rate_last(input rate_e sel);
    case (sel)
      RATE_EVERY_1:   return EVT_W'(0);
      RATE_EVERY_16:  return EVT_W'(15);
      RATE_EVERY_64:  return EVT_W'(63);
      default:        return EVT_W'(191);
    endcase
  endfunction

endpackage

// File: rtl/bpo_window.sv
module bpo_window #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned WIN_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clamp_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              start_o,
  output logic              abort_o,
  output logic              done_o,
  output logic [DATA_W-1:0] avg_o
);
  localparam int unsigned CNT_W = $clog2(WIN_LEN);
  localparam int unsigned SUM_W = DATA_W + CNT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

  logic              clamp_q;
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SUM_W-1:0]  acc_q;
  logic [SUM_W-1:0]  sum_q;
  logic              done_q;
  logic [SUM_W-1:0]  acc_next;

  assign start_o  = clamp_q & ~clamp_i;
  assign abort_o  = active_q & clamp_i;
  assign acc_next = acc_q + SUM_W'(sample_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clamp_q  <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      sum_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      clamp_q <= clamp_i;
      done_q  <= 1'b0;
      if (start_o) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
        acc_q    <= SUM_W'(sample_i);
      end else if (abort_o) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        acc_q <= acc_next;
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          sum_q    <= acc_next;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign avg_o  = sum_q[SUM_W-1:CNT_W];

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !done_o);  // R6
  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(active_q) && !$past(clamp_i)));  // R2

endmodule

// File: rtl/bpo_rate_gate.sv
module bpo_rate_gate
  import bpo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] rate_i,
  output logic       apply_o
);
  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] last;
  logic             wrap;

  assign last = rate_last(rate_e'(rate_i));
  assign wrap = (evt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q   <= '0;
      apply_o <= 1'b0;
    end else if (start_i) begin
      apply_o <= wrap;
      evt_q   <= wrap ? '0 : evt_q + EVT_W'(1);
    end
  end

  AST_RATE_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && rate_i == 2'b00) |=> apply_o);  // R7

endmodule

// File: rtl/bpo_step.sv
module bpo_step
  import bpo_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned TGT_W  = 11,
  parameter int unsigned CORR_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     done_i,
  input  logic [DATA_W-1:0]        avg_i,
  input  logic signed [TGT_W-1:0]  target_i,
  input  logic                     apply_i,
  input  logic                     auto_en_i,
  input  logic                     hold_i,
  output logic signed [CORR_W-1:0] corr_o,
  output logic                     take_o
);
  localparam int unsigned ERR_W = TGT_W + 1;
  localparam logic signed [CORR_W-1:0] CMAX = CORR_W'((1 << (CORR_W - 1)) - 1);
  localparam logic signed [CORR_W-1:0] CMIN = -CMAX;

  function automatic logic signed [ERR_W-1:0] calc_err(
      input logic signed [TGT_W-1:0] tgt, input logic [DATA_W-1:0] avg);
    return ERR_W'(tgt) - $signed(ERR_W'(avg));
  endfunction

  function automatic step_e calc_step(input logic signed [ERR_W-1:0] e);
    if (e > ERR_W'(1))       return STEP_UP;
    else if (e < -ERR_W'(1)) return STEP_DOWN;
    else                     return STEP_NONE;
  endfunction

  logic signed [CORR_W-1:0] corr_q;
  logic                     once_q;
  logic signed [ERR_W-1:0]  err;
  step_e                    dir;

  assign err    = calc_err(target_i, avg_i);
  assign dir    = calc_step(err);
  assign take_o = done_i & apply_i & auto_en_i & (target_i != '0) & ~(hold_i & once_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_q <= '0;
      once_q <= 1'b0;
    end else begin
      once_q <= auto_en_i & hold_i & (once_q | take_o);
      if (take_o) begin
        if (dir == STEP_UP && corr_q != CMAX)        corr_q <= corr_q + CORR_W'(1);
        else if (dir == STEP_DOWN && corr_q != CMIN) corr_q <= corr_q - CORR_W'(1);
      end
    end
  end

  assign corr_o = corr_q;

  AST_CORR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_q <= CMAX) && (corr_q >= CMIN));  // R4
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_q != $past(corr_q)) |-> ((corr_q - $past(corr_q) == CORR_W'(1)) ||
                                   ($past(corr_q) - corr_q == CORR_W'(1))));  // R3
  AST_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && target_i == '0) |=> $stable(corr_q));  // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && once_q) |=> $stable(corr_q));  // R8

endmodule

// File: rtl/backporch_offset_trim.sv
module backporch_offset_trim #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned TGT_W   = 11,
  parameter int unsigned CORR_W  = 9,
  parameter int unsigned WIN_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en_i,
  input  logic              hold_i,
  input  logic [1:0]        rate_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic [CORR_W-1:0] manual_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              clamp_i,
  output logic [CORR_W-1:0] offset_o
);
  logic                     win_start;
  logic                     win_abort;
  logic                     win_done;
  logic [DATA_W-1:0]        win_avg;
  logic                     rate_apply;
  logic signed [CORR_W-1:0] learned;
  logic                     upd_take;

  bpo_window #(.DATA_W(DATA_W), .WIN_LEN(WIN_LEN)) u_window (
    .clk(clk), .rst_n(rst_n), .clamp_i(clamp_i), .sample_i(sample_i),
    .start_o(win_start), .abort_o(win_abort), .done_o(win_done), .avg_o(win_avg)
  );

  bpo_rate_gate u_rate (
    .clk(clk), .rst_n(rst_n), .start_i(win_start), .rate_i(rate_i), .apply_o(rate_apply)
  );

  bpo_step #(.DATA_W(DATA_W), .TGT_W(TGT_W), .CORR_W(CORR_W)) u_step (
    .clk(clk), .rst_n(rst_n), .done_i(win_done), .avg_i(win_avg),
    .target_i($signed(target_i)), .apply_i(rate_apply), .auto_en_i(auto_en_i),
    .hold_i(hold_i), .corr_o(learned), .take_o(upd_take)
  );

  assign offset_o = auto_en_i ? learned : manual_i;

  AST_MANUAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en_i |=> $stable(learned));  // R9
  AST_NO_TAKE_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    win_abort |=> !upd_take);  // R6

endmodule

// File: tb/test_backporch_offset_trim.sv
module test_backporch_offset_trim;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_en = 1'b1;
  logic       hold = 1'b0;
  logic [1:0] rate = 2'b00;
  logic [10:0] target = 11'd0;
  logic [8:0] manual = 9'd0;
  logic [9:0] sample = 10'd0;
  logic       clamp = 1'b0;
  logic [8:0] offset;

  int errors = 0;
  int checks = 0;
  int exp_corr = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  backporch_offset_trim i_backporch_offset_trim (
    .clk(clk), .rst_n(rst_n), .auto_en_i(auto_en), .hold_i(hold), .rate_i(rate),
    .target_i(target), .manual_i(manual), .sample_i(sample), .clamp_i(clamp),
    .offset_o(offset)
  );

  // {target[10:0], a[9:0], b[9:0], delta[1:0]} ; delta 01=+1, 11=-1, 00=0
  localparam logic [32:0] VECS [13] = '{
    {11'd100,  10'd100,  10'd100,  2'b00},
    {11'd101,  10'd100,  10'd100,  2'b00},
    {11'd102,  10'd100,  10'd100,  2'b01},
    {11'd98,   10'd100,  10'd100,  2'b11},
    {11'd99,   10'd100,  10'd100,  2'b00},
    {11'd102,  10'd100,  10'd101,  2'b01},
    {11'd101,  10'd100,  10'd101,  2'b00},
    {11'h7FB,  10'd10,   10'd10,   2'b11},
    {11'h400,  10'd0,    10'd0,    2'b11},
    {11'd1023, 10'd1023, 10'd1023, 2'b00},
    {11'd600,  10'd0,    10'd1023, 2'b01},
    {11'd2,    10'd3,    10'd3,    2'b00},
    {11'd2,    10'd4,    10'd4,    2'b11}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clamp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_corr = 0;
  endtask

  // clamp high 2 cycles, 16 window samples alternating a/b, then outside data
  task automatic pulse(input logic [9:0] a, input logic [9:0] b, input logic [9:0] outside);
    clamp = 1'b1; sample = outside;
    repeat (2) @(negedge clk);
    clamp = 1'b0;
    for (int k = 0; k < 16; k++) begin
      sample = k[0] ? b : a;
      @(negedge clk);
    end
    sample = outside;
    @(negedge clk);
  endtask

  function automatic int so(input logic [8:0] v);
    return int'($signed(v));
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    do_reset();
    chk("R1 reset", so(offset), 0);

    // R2 R3: table of patterns, outside samples set to 1023
    for (int i = 0; i < 13; i++) begin
      logic [32:0] v;
      v = VECS[i];
      target = v[32:22];
      pulse(v[21:12], v[11:2], 10'd1023);
      if (v[1:0] == 2'b01) exp_corr++;
      else if (v[1:0] == 2'b11) exp_corr--;
      chk($sformatf("R3 vector %0d", i), so(offset), exp_corr);
    end

    // R2: update not visible one edge before due
    target = 11'd500;
    clamp = 1'b1; repeat (2) @(negedge clk);
    clamp = 1'b0; sample = 10'd0;
    repeat (16) @(negedge clk);
    chk("R2 not early", so(offset), exp_corr);
    @(negedge clk);
    exp_corr++;
    chk("R2 on time", so(offset), exp_corr);

    // R5: zero target
    target = 11'd0;
    pulse(10'd0, 10'd0, 10'd0);
    chk("R5 zero target", so(offset), exp_corr);

    // R6: abort
    target = 11'd500;
    clamp = 1'b1; repeat (2) @(negedge clk);
    clamp = 1'b0; sample = 10'd0; repeat (8) @(negedge clk);
    clamp = 1'b1; repeat (20) @(negedge clk);
    chk("R6 abort", so(offset), exp_corr);
    pulse(10'd0, 10'd0, 10'd0);
    exp_corr++;
    chk("R6 next window", so(offset), exp_corr);

    // R9: manual bypass
    auto_en = 1'b0; manual = 9'h138;
    @(negedge clk);
    chk("R9 manual", so(offset), -200);
    pulse(10'd0, 10'd0, 10'd0);
    chk("R9 no update", so(offset), -200);
    auto_en = 1'b1;
    @(negedge clk);
    chk("R9 restored", so(offset), exp_corr);

    // R4: saturation
    do_reset();
    target = 11'd1023;
    for (int i = 0; i < 260; i++) pulse(10'd0, 10'd0, 10'd0);
    chk("R4 upper", so(offset), 255);
    target = 11'h400;
    for (int i = 0; i < 520; i++) pulse(10'd1023, 10'd1023, 10'd1023);
    chk("R4 lower", so(offset), -255);

    // R7: rate choices
    begin
      int per [3] = '{16, 64, 192};
      logic [1:0] sel [3] = '{2'b01, 2'b10, 2'b11};
      for (int r = 0; r < 3; r++) begin
        rate = sel[r];
        do_reset();
        target = 11'd500;
        for (int i = 0; i < per[r] - 1; i++) pulse(10'd0, 10'd0, 10'd0);
        chk($sformatf("R7 rate %0d early", per[r]), so(offset), 0);
        pulse(10'd0, 10'd0, 10'd0);
        chk($sformatf("R7 rate %0d due", per[r]), so(offset), 1);
      end
    end
    rate = 2'b00;

    // R8: hold one-shot
    do_reset();
    hold = 1'b1;
    target = 11'd0;
    pulse(10'd0, 10'd0, 10'd0);
    chk("R8 R5 zero not counted", so(offset), 0);
    target = 11'd500;
    pulse(10'd0, 10'd0, 10'd0);
    chk("R8 first", so(offset), 1);
    for (int i = 0; i < 3; i++) pulse(10'd0, 10'd0, 10'd0);
    chk("R8 frozen", so(offset), 1);
    hold = 1'b0;
    pulse(10'd0, 10'd0, 10'd0);
    chk("R8 released", so(offset), 2);

    finish_run();
  end

endmodule